// File: doc/BRIEF.md
# Strided IDE Register Bridge

This block is a slave on a 32-bit memory-mapped host bus. It turns byte, halfword and word accesses inside a 4 KiB window into single register transactions on an IDE task-file port. Each register takes a 16-byte slot in the window. The slot number selects one of four paths:

- one of the seven task-file registers,
- the device control register, which reads back as the alternate status register,
- the data port,
- nothing.

Data-port traffic is byte-swapped so that the host and the device see their own lane order.

The host holds a request with `host_valid` until the bridge answers with a one-cycle `host_ready` pulse. Mapped accesses go to the task-file side through a request/acknowledge handshake. Unmapped accesses are answered locally: reads return all ones and writes are discarded.

Top module: `strided_ide_bridge`

## Requirements
- R1: The register index is `host_addr[11:4]`, so the value of `host_addr[3:0]` has no effect on which register is reached.
- R2: A byte access (size code 00) at index 1 to 7 is forwarded with `tf_target` = 1 (task file) and `tf_reg` equal to the index. A read returns the acknowledged byte in bits 7:0, with bits 31:8 at zero.
- R3: A byte access at index 8 or index 22 is forwarded with `tf_target` = 2. A write goes to the device control register and a read returns the alternate status byte.
- R4: A byte access at any other index is never forwarded. A read returns 0x000000FF and a write is discarded.
- R5: A halfword (size code 01) or word (size code 10) access at index 0 is forwarded with `tf_target` = 3 and `tf_size` equal to the access size. Data is byte-reversed over 16 bits for a halfword and over 32 bits for a word, on both writes and reads.
- R6: A halfword or word access at any nonzero index is never forwarded. A halfword read returns 0x0000FFFF and a word read returns 0xFFFFFFFF.
- R7: Size code 11 is reserved. Such an access is never forwarded, and a read returns 0xFFFFFFFF.
- R8: `tf_req` stays high, with its target, register, size, direction and data unchanged, until `tf_ack`. `host_ready` pulses for exactly one cycle, in the cycle after the acknowledge. A write response carries `host_rdata` = 0.
- R9: A forwarded write to a task-file or control register carries only byte lane 0 of `host_wdata` on `tf_wdata`, with bits 31:8 at zero.
- R10: A synchronous active-high `rst` returns the bridge to idle. Afterwards `tf_req` and `host_ready` are low and `host_rdata` is zero, including when the reset arrives in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request, held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| host_addr | input | 12 | Byte offset within the window |
| host_wdata | input | 32 | Write data, host lane order |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| tf_req | output | 1 | Task-file port request |
| tf_we | output | 1 | Task-file port write |
| tf_target | output | 2 | 1 task file, 2 control/alt status, 3 data port |
| tf_reg | output | 3 | Task-file register number (0 for other targets) |
| tf_size | output | 2 | Access size code forwarded to the device |
| tf_wdata | output | 32 | Write data, device lane order |
| tf_ack | input | 1 | Task-file port acknowledge |
| tf_rdata | input | 32 | Read data from the device, device lane order |

## Verification
The checks rely on two assumptions about the inputs. First, the host holds `host_valid` and its fields steady from the first cycle of a request until `host_ready`. Second, the device side raises `tf_ack` only while `tf_req` is high and for one cycle per request. The bench's host task keeps the fields constant through each transaction and drops `host_valid` on the ready pulse. The modelled device acknowledges after a fixed delay and clears its acknowledge straight away. The assertions check the request-hold, single-pulse and lane rules under those assumptions. The bench adds checks on the swapped values, the all-ones fills and the forwarding count at the ports.

// File: rtl/sib_pkg.sv
package sib_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int SLOT_LOG2 = 4;
    localparam int IDX_W     = ADDR_W - SLOT_LOG2;
    localparam int REG_W     = 3;
    localparam int TF_FIRST  = 1;
    localparam int TF_LAST   = 7;
    localparam int CTL_IDX_A = 8;
    localparam int CTL_IDX_B = 22;
    localparam int DATA_IDX  = 0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TASK = 2'd1,
        TGT_CTRL = 2'd2,
        TGT_DATA = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        target_e          tgt;
        logic [REG_W-1:0] sel;
        size_e            size;
    } route_t;

    function automatic logic [15:0] swap16(input logic [15:0] d);
        return {d[7:0], d[15:8]};
    endfunction

    function automatic logic [31:0] swap32(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    // Value an unmapped read returns for a given access size.
    function automatic logic [DATA_W-1:0] miss_fill(input size_e s);
        case (s)
            SZ_BYTE: return {{(DATA_W-8){1'b0}}, 8'hFF};
            SZ_HALF: return {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: return {DATA_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/sib_decode.sv
module sib_decode
    import sib_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  size_e             size,
    output route_t            route
);
    logic [IDX_W-1:0] idx;
    logic             tf_hit;
    logic             ctl_hit;
    logic             dat_hit;

    // R1: slot index ignores the low nibble
    assign idx     = addr[ADDR_W-1:SLOT_LOG2];
    assign tf_hit  = (idx >= IDX_W'(TF_FIRST)) && (idx <= IDX_W'(TF_LAST));
    assign ctl_hit = (idx == IDX_W'(CTL_IDX_A)) || (idx == IDX_W'(CTL_IDX_B));
    assign dat_hit = (idx == IDX_W'(DATA_IDX));

    always_comb begin
        route.tgt  = TGT_NONE;
        route.sel  = '0;
        route.size = size;
        case (size)
            SZ_BYTE: begin
                if (tf_hit) begin
                    route.tgt = TGT_TASK;
                    route.sel = idx[REG_W-1:0];
                end else if (ctl_hit) begin
                    route.tgt = TGT_CTRL;
                end
            end
            SZ_HALF, SZ_WORD: begin
                if (dat_hit) route.tgt = TGT_DATA;
            end
            default: route.tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/sib_lane.sv
module sib_lane
    import sib_pkg::*;
(
    input  size_e             size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        case (size)
            SZ_BYTE: dout = {{(DATA_W-8){1'b0}}, din[7:0]};
            SZ_HALF: dout = {{(DATA_W-16){1'b0}}, swap16(din[15:0])};
            SZ_WORD: dout = swap32(din);
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/sib_ctrl.sv
module sib_ctrl
    import sib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic              host_write,
    input  route_t            route_in,
    input  logic [DATA_W-1:0] wlane_in,
    input  logic [DATA_W-1:0] rlane_in,
    input  logic              tf_ack,
    output route_t            route_q,
    output logic              we_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              req,
    output logic              ready,
    output logic [DATA_W-1:0] rdata_q
);
    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            route_q <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (host_valid) begin
                        route_q <= route_in;
                        we_q    <= host_write;
                        wdata_q <= wlane_in;
                        if (route_in.tgt != TGT_NONE) begin
                            phase <= PH_WAIT;
                        end else begin
                            rdata_q <= host_write ? '0 : miss_fill(route_in.size);
                            phase   <= PH_DONE;
                        end
                    end
                end
                PH_WAIT: begin
                    if (tf_ack) begin
                        rdata_q <= we_q ? '0 : rlane_in;
                        phase   <= PH_DONE;
                    end
                end
                PH_DONE: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign req   = (phase == PH_WAIT);
    assign ready = (phase == PH_DONE);
endmodule

// File: rtl/strided_ide_bridge.sv
module strided_ide_bridge
    import sib_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic [1:0]  host_size,
    input  logic [11:0] host_addr,
    input  logic [31:0] host_wdata,
    output logic        host_ready,
    output logic [31:0] host_rdata,
    output logic        tf_req,
    output logic        tf_we,
    output logic [1:0]  tf_target,
    output logic [2:0]  tf_reg,
    output logic [1:0]  tf_size,
    output logic [31:0] tf_wdata,
    input  logic        tf_ack,
    input  logic [31:0] tf_rdata
);
    route_t            route_now;
    route_t            route_q;
    logic [DATA_W-1:0] wlane;
    logic [DATA_W-1:0] rlane;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;

    sib_decode u_decode (
        .addr  (host_addr),
        .size  (size_e'(host_size)),
        .route (route_now)
    );

    // Host lanes toward the device
    sib_lane u_lane_w (
        .size (route_now.size),
        .din  (host_wdata),
        .dout (wlane)
    );

    // Device lanes toward the host
    sib_lane u_lane_r (
        .size (route_q.size),
        .din  (tf_rdata),
        .dout (rlane)
    );

    sib_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_write (host_write),
        .route_in   (route_now),
        .wlane_in   (wlane),
        .rlane_in   (rlane),
        .tf_ack     (tf_ack),
        .route_q    (route_q),
        .we_q       (we_q),
        .wdata_q    (wdata_q),
        .req        (tf_req),
        .ready      (host_ready),
        .rdata_q    (host_rdata)
    );

    assign tf_we     = we_q;
    assign tf_target = route_q.tgt;
    assign tf_reg    = route_q.sel;
    assign tf_size   = route_q.size;
    assign tf_wdata  = wdata_q;
endmodule

// File: rtl/sib_checker.sv
module sib_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_ready,
    input logic        tf_req,
    input logic        tf_we,
    input logic [1:0]  tf_target,
    input logic [2:0]  tf_reg,
    input logic [1:0]  tf_size,
    input logic [31:0] tf_wdata,
    input logic        tf_ack
);
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        tf_req && !tf_ack |=> tf_req && $stable(tf_target) && $stable(tf_reg)
                              && $stable(tf_size) && $stable(tf_we) && $stable(tf_wdata));

    a_r8_ready_after_ack: assert property (@(posedge clk) disable iff (rst)
        tf_req && tf_ack |=> host_ready);

    a_r8_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);

    a_r4_no_req_at_ready: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> !tf_req);

    a_r2_task_index: assert property (@(posedge clk) disable iff (rst)
        tf_req && tf_target == 2'd1 |-> tf_reg != 3'd0);

    a_r5_data_width: assert property (@(posedge clk) disable iff (rst)
        tf_req && tf_target == 2'd3 |-> (tf_size == 2'b01 || tf_size == 2'b10));

    a_r9_lane_zero: assert property (@(posedge clk) disable iff (rst)
        tf_req && tf_we && tf_target != 2'd3 |-> tf_wdata[31:8] == 24'd0);

    a_r10_target_valid: assert property (@(posedge clk) disable iff (rst)
        tf_req |-> tf_target != 2'd0);
endmodule

bind strided_ide_bridge sib_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_ready (host_ready),
    .tf_req     (tf_req),
    .tf_we      (tf_we),
    .tf_target  (tf_target),
    .tf_reg     (tf_reg),
    .tf_size    (tf_size),
    .tf_wdata   (tf_wdata),
    .tf_ack     (tf_ack)
);

// File: tb/strided_ide_bridge_tb_top.sv
module strided_ide_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [1:0]  host_size = 2'b00;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        tf_req, tf_we;
    logic [1:0]  tf_target, tf_size;
    logic [2:0]  tf_reg;
    logic [31:0] tf_wdata;
    logic        tf_ack = 1'b0;
    logic [31:0] tf_rdata = '0;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;  // 50 MHz

    strided_ide_bridge dut_i (.*);

    // Task-file device model
    localparam int ACK_DLY = 2;
    logic [7:0]  tf_regs [8];
    logic [7:0]  ctrl_reg;
    localparam logic [7:0]  ALT_STAT = 8'h58;
    localparam logic [31:0] DATA_RD  = 32'h11223344;
    logic [31:0] data_wr;
    logic [1:0]  data_wr_size;
    logic [1:0]  last_tgt;
    logic [31:0] last_wdata;
    int          fwd_count = 0;
    int          dly = 0;

    initial begin
        for (int i = 0; i < 8; i++) tf_regs[i] = 8'h10 + 8'(i);
        ctrl_reg = 8'h00; data_wr = '0; data_wr_size = '0;
        last_tgt = '0; last_wdata = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            tf_ack <= 1'b0;
            dly    <= 0;
        end else if (tf_req && !tf_ack) begin
            if (dly == ACK_DLY) begin
                dly       <= 0;
                tf_ack    <= 1'b1;
                fwd_count <= fwd_count + 1;
                last_tgt  <= tf_target;
                if (tf_we) begin
                    last_wdata <= tf_wdata;
                    case (tf_target)
                        2'd1: tf_regs[tf_reg] <= tf_wdata[7:0];
                        2'd2: ctrl_reg <= tf_wdata[7:0];
                        2'd3: begin data_wr <= tf_wdata; data_wr_size <= tf_size; end
                        default: ;
                    endcase
                    tf_rdata <= 32'hDEAD_0000;
                end else begin
                    case (tf_target)
                        2'd1: tf_rdata <= {24'hABCDEF, tf_regs[tf_reg]};
                        2'd2: tf_rdata <= {24'h123456, ALT_STAT};
                        default: tf_rdata <= DATA_RD;
                    endcase
                end
            end else begin
                dly <= dly + 1;
            end
        end else begin
            tf_ack <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One host transaction; lat = negedges from ack seen to ready seen (-1 if no ack)
    task automatic access(input logic we, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int fwd, output int lat);
        int f0 = fwd_count;
        int ack_at = -1;
        int n = 0;
        bit got = 0;
        @(negedge clk);
        host_valid = 1'b1; host_write = we; host_size = sz;
        host_addr = a; host_wdata = wd;
        lat = -1;
        rd  = '0;
        while (!got && n < 50) begin
            @(negedge clk);
            n++;
            if (tf_ack && ack_at < 0) ack_at = n;
            if (host_ready) begin
                got = 1;
                rd  = host_rdata;
                if (ack_at >= 0) lat = n - ack_at;
            end
        end
        host_valid = 1'b0;
        if (!got) begin
            errors++; checks++;
            $display("FAIL R8 no host_ready: actual=0 expected=1");
        end
        fwd = fwd_count - f0;
    endtask

    // Vector: {we, size, addr, wdata, expected rdata, expected forwarded}
    localparam int NV = 15;
    localparam logic [79:0] VEC [NV] = '{
        {1'b0, 2'b00, 12'h010, 32'h0,        32'h00000011, 1'b1}, // R2
        {1'b0, 2'b00, 12'h070, 32'h0,        32'h00000017, 1'b1}, // R2
        {1'b1, 2'b00, 12'h030, 32'hAABBCC5A, 32'h00000000, 1'b1}, // R2 R8 write
        {1'b0, 2'b00, 12'h03F, 32'h0,        32'h0000005A, 1'b1}, // R1
        {1'b0, 2'b00, 12'h080, 32'h0,        32'h00000058, 1'b1}, // R3
        {1'b0, 2'b00, 12'h16C, 32'h0,        32'h00000058, 1'b1}, // R3
        {1'b0, 2'b00, 12'h000, 32'h0,        32'h000000FF, 1'b0}, // R4
        {1'b0, 2'b00, 12'h090, 32'h0,        32'h000000FF, 1'b0}, // R4
        {1'b0, 2'b01, 12'h000, 32'h0,        32'h00004433, 1'b1}, // R5
        {1'b0, 2'b10, 12'h008, 32'h0,        32'h44332211, 1'b1}, // R5 R1
        {1'b0, 2'b01, 12'h010, 32'h0,        32'h0000FFFF, 1'b0}, // R6
        {1'b0, 2'b10, 12'h160, 32'h0,        32'hFFFFFFFF, 1'b0}, // R6
        {1'b0, 2'b00, 12'hFF0, 32'h0,        32'h000000FF, 1'b0}, // R4
        {1'b0, 2'b11, 12'h000, 32'h0,        32'hFFFFFFFF, 1'b0}, // R7
        {1'b1, 2'b00, 12'h0A0, 32'h00000099, 32'h00000000, 1'b0}  // R4 write drop
    };

    function automatic string vtag(input int i);
        case (i)
            0, 1, 2: return "R2";
            3:       return "R1";
            4, 5:    return "R3";
            8, 9:    return "R5";
            10, 11:  return "R6";
            13:      return "R7";
            default: return "R4";
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int fwd, lat;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", {30'd0, host_ready, tf_req}, 32'd0, "ready/req in reset");
        check("R10", host_rdata, 32'd0, "rdata in reset");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][79], VEC[i][78:77], VEC[i][76:65], VEC[i][64:33], rd, fwd, lat);
            check(vtag(i), rd, VEC[i][32:1], $sformatf("vector %0d rdata", i));
            check(vtag(i), 32'(fwd), 32'(VEC[i][0]), $sformatf("vector %0d forwarded", i));
        end
        check("R2", {24'd0, tf_regs[3]}, 32'h5A, "task reg 3 after write");
        check("R4", {24'd0, tf_regs[2]}, 32'h12, "task reg untouched by dropped write");

        // R9 lane 0 only on task-file write
        access(1'b1, 2'b00, 12'h050, 32'hF0E0D0C7, rd, fwd, lat);
        check("R9", last_wdata, 32'h000000C7, "task write lanes");
        check("R2", {29'd0, tf_regs[5] == 8'hC7, last_tgt}, {29'd0, 1'b1, 2'd1}, "task write target");

        // R3 control via second alias
        access(1'b1, 2'b00, 12'h160, 32'h12345677, rd, fwd, lat);
        check("R3", {24'd0, ctrl_reg}, 32'h77, "control write");
        check("R9", last_wdata, 32'h00000077, "control write lanes");

        // R5 data port writes
        access(1'b1, 2'b01, 12'h000, 32'h1234ABCD, rd, fwd, lat);
        check("R5", data_wr, 32'h0000CDAB, "half write swap");
        check("R5", {30'd0, data_wr_size}, 32'd1, "half write size");
        access(1'b1, 2'b10, 12'h004, 32'hDEADBEEF, rd, fwd, lat);
        check("R5", data_wr, 32'hEFBEADDE, "word write swap");
        check("R8", rd, 32'd0, "write response rdata");

        // R8 latency from ack to ready
        access(1'b0, 2'b00, 12'h020, 32'h0, rd, fwd, lat);
        check("R8", 32'(lat), 32'd1, "ack to ready cycles");
        @(negedge clk);
        check("R8", {31'd0, host_ready}, 32'd0, "ready single pulse");

        // R10 reset in the middle of a transaction
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_size = 2'b00; host_addr = 12'h040;
        @(negedge clk);
        check("R10", {31'd0, tf_req}, 32'd1, "request before reset");
        rst = 1'b1; host_valid = 1'b0;
        @(negedge clk);
        check("R10", {30'd0, host_ready, tf_req}, 32'd0, "idle after mid reset");
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check("R10", {30'd0, host_ready, tf_req}, 32'd0, "stays idle after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule